// File: doc/BRIEF.md
# Harmonic Distortion and Fuzz Mixer

This block is a streaming distortion stage for signed Q1.15 audio samples. For every accepted sample it forms the second, third, fourth and fifth integer powers of the signal, a hard-clipped copy of the signal, and a fuzz term made by multiplying the signal with pseudo-random noise from an internal 16-bit LFSR. Each of these six terms is weighted by its own unsigned gain. The weighted terms are added to the unmodified input, and the total is saturated back into Q1.15.

A sample is offered with `in_valid`; the result leaves on `out_data` with `out_valid` a fixed number of clocks later. Samples may arrive back to back or with gaps. The gain inputs are static configuration. They are read in the last pipeline stage, so they may only be changed while no sample is in flight.

Top module: `hd_fuzz_mixer`

## Requirements
- R1: While `rst` is high and on the first cycle after it falls, `out_valid` is 0 and `out_data` is 0.
- R2: A sample presented with `in_valid` high at rising edge e appears on `out_data` with `out_valid` high after rising edge e+2, which is the third edge counted from e. Each accepted sample yields exactly one result, in order, whether samples arrive back to back or with gaps.
- R3: The dry input is always part of the sum. When every gain is 0, `out_data` equals `in_x`.
- R4: Products are taken in Q1.15 as floor(a*b / 2^15). The one product that overflows, -1 times -1, gives 32767. The square term is x2 = x*x. A gain g is an unsigned 8-bit Q2.6 value (64 means 1.0). The square term contributes floor(x2*g / 64).
- R5: The third power is x3 = x2*x, the fourth power is x4 = x2*x2, and the fifth power is x5 = x4*x. These three terms are boosted by a factor of 4 (a left shift of 2), so each contributes floor(term*g*4 / 64).
- R6: The clip term is `in_x` limited to the range [-8192, +8192], which is ±0.25 of full scale. It contributes floor(clip*g / 64).
- R7: The fuzz term is x*n. Here n is the LFSR state read as a signed 16-bit value.
  - The LFSR reloads 0xACE1 on reset.
  - On each accepted sample it shifts left, with s[15]^s[13]^s[12]^s[10] entering bit 0.
  - The state used for a sample is the state before that sample's step.
  - The fuzz term contributes floor(fuzz*g / 64).
- R8: The exact sum of the dry input and the six contributions is saturated to [-32768, 32767].
- R9: A term whose gain is 0 adds nothing. With only one gain nonzero, the output is the dry input plus that one contribution.
- R10: `out_data` holds its last value while `out_valid` is low. The LFSR does not step while `in_valid` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Input sample strobe |
| in_x | input | 16 | Input sample, signed Q1.15 |
| g_sq | input | 8 | Square-term gain, Q2.6 |
| g_cube | input | 8 | Third-power gain, Q2.6 |
| g_quad | input | 8 | Fourth-power gain, Q2.6 |
| g_quint | input | 8 | Fifth-power gain, Q2.6 |
| g_clip | input | 8 | Clip-term gain, Q2.6 |
| g_fuzz | input | 8 | Fuzz-term gain, Q2.6 |
| out_valid | output | 1 | Output sample strobe |
| out_data | output | 16 | Mixed sample, signed Q1.15 |

## Verification
The assertions check several properties on every cycle:
- the three-edge valid latency;
- the holding of `out_data` while no result leaves;
- that the noise state is never zero and moves only with accepted samples;
- that the clipped copy never leaves ±8192.

The arithmetic can only be shown by the scenarios, each compared against an independent model of the requirements:
- the floor truncation;
- the -1 times -1 corner;
- the boost on the upper powers;
- the exact noise sequence;
- saturation at both rails.

// File: rtl/hd_fuzz_pkg.sv
package hd_fuzz_pkg;
    localparam int SAMP_W   = 16;
    localparam int GAIN_W   = 8;
    localparam int GAIN_FR  = 6;
    localparam int N_TERMS  = 6;
    // term slots inside the mixer
    localparam int T_SQ    = 0;
    localparam int T_CUBE  = 1;
    localparam int T_QUAD  = 2;
    localparam int T_QUINT = 3;
    localparam int T_CLIP  = 4;
    localparam int T_FUZZ  = 5;
    // which slots receive the harmonic boost
    localparam logic [N_TERMS-1:0] BOOST_MASK = 6'b001110;

    typedef logic signed [SAMP_W-1:0] samp_t;
    typedef logic [GAIN_W-1:0]        gain_t;
endpackage

// File: rtl/hd_qmul.sv
module hd_qmul #(
    parameter int W = 16
) (
    input  logic signed [W-1:0] a,
    input  logic signed [W-1:0] b,
    output logic signed [W-1:0] p
);
    localparam int PW = 2 * W;
    localparam logic signed [PW-1:0] POS_MAX = {{(W+1){1'b0}}, {(W-1){1'b1}}};

    logic signed [PW-1:0] full;
    logic signed [PW-1:0] shifted;

    always_comb begin
        full    = a * b;
        shifted = full >>> (W - 1);
        if (shifted > POS_MAX)
            p = POS_MAX[W-1:0];
        else
            p = shifted[W-1:0];
    end
endmodule

// File: rtl/hd_lfsr.sv
module hd_lfsr #(
    parameter logic [15:0] SEED = 16'hACE1
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        step,
    output logic [15:0] state
);
    logic fb;

    always_comb fb = state[15] ^ state[13] ^ state[12] ^ state[10];

    always_ff @(posedge clk) begin
        if (rst)
            state <= SEED;
        else if (step)
            state <= {state[14:0], fb};
    end
endmodule

// File: rtl/hd_mix.sv
module hd_mix
    import hd_fuzz_pkg::*;
#(
    parameter int W       = SAMP_W,
    parameter int GW      = GAIN_W,
    parameter int GFR     = GAIN_FR,
    parameter int NT      = N_TERMS,
    parameter int BOOST   = 2,
    parameter logic [NT-1:0] BMASK = BOOST_MASK
) (
    input  logic signed [W-1:0] dry,
    input  logic signed [W-1:0] term [NT],
    input  logic [GW-1:0]       gain [NT],
    output logic signed [W-1:0] mixed
);
    localparam int PW = W + GW + 1;
    localparam int AW = PW + BOOST + 5;
    localparam logic signed [AW-1:0] HI = {{(AW-W+1){1'b0}}, {(W-1){1'b1}}};
    localparam logic signed [AW-1:0] LO = {{(AW-W+1){1'b1}}, {(W-1){1'b0}}};

    logic signed [AW-1:0] contrib [NT];
    logic signed [AW-1:0] acc;

    for (genvar i = 0; i < NT; i++) begin : g_term
        logic signed [PW-1:0] prod;
        logic signed [AW-1:0] wide;
        always_comb begin
            prod = term[i] * $signed({1'b0, gain[i]});
            wide = AW'(prod);
        end
        if (BMASK[i]) begin : g_boost
            always_comb contrib[i] = (wide <<< BOOST) >>> GFR;
        end else begin : g_plain
            always_comb contrib[i] = wide >>> GFR;
        end
    end

    always_comb begin
        acc = AW'(dry);
        for (int k = 0; k < NT; k++)
            acc = acc + contrib[k];
        if (acc > HI)
            mixed = HI[W-1:0];
        else if (acc < LO)
            mixed = LO[W-1:0];
        else
            mixed = acc[W-1:0];
    end
endmodule

// File: rtl/hd_fuzz_mixer.sv
module hd_fuzz_mixer
    import hd_fuzz_pkg::*;
#(
    parameter int          W     = SAMP_W,
    parameter int          GW    = GAIN_W,
    parameter int          BOOST = 2,
    parameter logic [15:0] SEED  = 16'hACE1
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                in_valid,
    input  logic signed [W-1:0] in_x,
    input  logic [GW-1:0]       g_sq,
    input  logic [GW-1:0]       g_cube,
    input  logic [GW-1:0]       g_quad,
    input  logic [GW-1:0]       g_quint,
    input  logic [GW-1:0]       g_clip,
    input  logic [GW-1:0]       g_fuzz,
    output logic                out_valid,
    output logic signed [W-1:0] out_data
);
    localparam logic signed [W-1:0] CLIP_LIM = W'(1) <<< (W - 3);

    // stage 1
    logic [15:0]         lfsr_state;
    logic signed [W-1:0] noise;
    logic signed [W-1:0] sq_c, fuzz_c, clip_c;
    logic                v1;
    logic signed [W-1:0] s1_x, s1_x2, s1_clip, s1_fuzz;
    // stage 2
    logic signed [W-1:0] x3_c, x4_c;
    logic                v2;
    logic signed [W-1:0] s2_x, s2_x2, s2_x3, s2_x4, s2_clip, s2_fuzz;
    // stage 3
    logic signed [W-1:0] x5_c, mix_c;
    logic signed [W-1:0] terms [N_TERMS];
    logic [GW-1:0]       gains [N_TERMS];

    hd_lfsr #(.SEED(SEED)) u_lfsr (
        .clk(clk), .rst(rst), .step(in_valid), .state(lfsr_state)
    );

    always_comb noise = $signed(lfsr_state[W-1:0]);

    hd_qmul #(.W(W)) u_sq   (.a(in_x),  .b(in_x),  .p(sq_c));
    hd_qmul #(.W(W)) u_fuzz (.a(in_x),  .b(noise), .p(fuzz_c));

    always_comb begin
        if (in_x > CLIP_LIM)
            clip_c = CLIP_LIM;
        else if (in_x < -CLIP_LIM)
            clip_c = -CLIP_LIM;
        else
            clip_c = in_x;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            v1      <= 1'b0;
            s1_x    <= '0;
            s1_x2   <= '0;
            s1_clip <= '0;
            s1_fuzz <= '0;
        end else begin
            v1 <= in_valid;
            if (in_valid) begin
                s1_x    <= in_x;
                s1_x2   <= sq_c;
                s1_clip <= clip_c;
                s1_fuzz <= fuzz_c;
            end
        end
    end

    hd_qmul #(.W(W)) u_cube (.a(s1_x2), .b(s1_x),  .p(x3_c));
    hd_qmul #(.W(W)) u_quad (.a(s1_x2), .b(s1_x2), .p(x4_c));

    always_ff @(posedge clk) begin
        if (rst) begin
            v2      <= 1'b0;
            s2_x    <= '0;
            s2_x2   <= '0;
            s2_x3   <= '0;
            s2_x4   <= '0;
            s2_clip <= '0;
            s2_fuzz <= '0;
        end else begin
            v2 <= v1;
            if (v1) begin
                s2_x    <= s1_x;
                s2_x2   <= s1_x2;
                s2_x3   <= x3_c;
                s2_x4   <= x4_c;
                s2_clip <= s1_clip;
                s2_fuzz <= s1_fuzz;
            end
        end
    end

    hd_qmul #(.W(W)) u_quint (.a(s2_x4), .b(s2_x), .p(x5_c));

    always_comb begin
        terms[T_SQ]    = s2_x2;
        terms[T_CUBE]  = s2_x3;
        terms[T_QUAD]  = s2_x4;
        terms[T_QUINT] = x5_c;
        terms[T_CLIP]  = s2_clip;
        terms[T_FUZZ]  = s2_fuzz;
        gains[T_SQ]    = g_sq;
        gains[T_CUBE]  = g_cube;
        gains[T_QUAD]  = g_quad;
        gains[T_QUINT] = g_quint;
        gains[T_CLIP]  = g_clip;
        gains[T_FUZZ]  = g_fuzz;
    end

    hd_mix #(.W(W), .GW(GW), .BOOST(BOOST)) u_mix (
        .dry(s2_x), .term(terms), .gain(gains), .mixed(mix_c)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            out_valid <= 1'b0;
            out_data  <= '0;
        end else begin
            out_valid <= v2;
            if (v2)
                out_data <= mix_c;
        end
    end
endmodule

// File: rtl/hd_fuzz_mixer_chk.sv
module hd_fuzz_mixer_chk #(
    parameter int W = 16
) (
    input logic                clk,
    input logic                rst,
    input logic                in_valid,
    input logic                out_valid,
    input logic signed [W-1:0] out_data,
    input logic [15:0]         lfsr_state,
    input logic signed [W-1:0] s1_clip
);
    localparam logic signed [W-1:0] LIM = W'(1) <<< (W - 3);

    assert_latency_R2: assert property (@(posedge clk) disable iff (rst)
        in_valid |-> ##3 out_valid);

    assert_no_spurious_R2: assert property (@(posedge clk) disable iff (rst)
        !in_valid |-> ##3 !out_valid);

    assert_hold_out_R10: assert property (@(posedge clk) disable iff (rst)
        !out_valid |-> $stable(out_data));

    assert_lfsr_idle_R10: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> $stable(lfsr_state));

    assert_lfsr_nonzero_R7: assert property (@(posedge clk) disable iff (rst)
        lfsr_state != 16'h0000);

    assert_clip_range_R6: assert property (@(posedge clk) disable iff (rst)
        (s1_clip <= LIM) && (s1_clip >= -LIM));
endmodule

bind hd_fuzz_mixer hd_fuzz_mixer_chk #(.W(W)) u_chk (
    .clk(clk), .rst(rst), .in_valid(in_valid), .out_valid(out_valid),
    .out_data(out_data), .lfsr_state(lfsr_state), .s1_clip(s1_clip)
);

// File: tb/tb_hd_fuzz_mixer.sv
module tb_hd_fuzz_mixer;
    logic               clk = 1'b0;
    logic               rst = 1'b1;
    logic               in_valid = 1'b0;
    logic signed [15:0] in_x = '0;
    logic [7:0]         g [6];
    logic               out_valid;
    logic signed [15:0] out_data;

    int n_chk = 0;
    int n_bad = 0;
    logic [15:0] m_lfsr;
    longint exp_q[$];
    string  tag_q[$];

    always #2.5 clk = ~clk;

    hd_fuzz_mixer dut (
        .clk(clk), .rst(rst), .in_valid(in_valid), .in_x(in_x),
        .g_sq(g[0]), .g_cube(g[1]), .g_quad(g[2]), .g_quint(g[3]),
        .g_clip(g[4]), .g_fuzz(g[5]),
        .out_valid(out_valid), .out_data(out_data)
    );

    function automatic longint qm(longint a, longint b);
        longint r;
        r = (a * b) >>> 15;
        if (r > 32767) r = 32767;
        return r;
    endfunction

    function automatic longint scl(longint t, longint gg, int boost);
        return (t * gg * (longint'(1) << boost)) >>> 6;
    endfunction

    task automatic check(string req, longint act, longint exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic send(longint x, string req);
        longint x2, x3, x4, x5, cl, fz, s;
        logic fb;
        @(negedge clk);
        in_valid = 1'b1;
        in_x = 16'(x);
        x2 = qm(x, x);
        x3 = qm(x2, x);
        x4 = qm(x2, x2);
        x5 = qm(x4, x);
        cl = (x > 8192) ? 8192 : ((x < -8192) ? -8192 : x);
        fz = qm(x, longint'($signed(m_lfsr)));
        s = x + scl(x2, g[0], 0) + scl(x3, g[1], 2) + scl(x4, g[2], 2)
              + scl(x5, g[3], 2) + scl(cl, g[4], 0) + scl(fz, g[5], 0);
        if (s > 32767) s = 32767;
        if (s < -32768) s = -32768;
        exp_q.push_back(s);
        tag_q.push_back(req);
        fb = m_lfsr[15] ^ m_lfsr[13] ^ m_lfsr[12] ^ m_lfsr[10];
        m_lfsr = {m_lfsr[14:0], fb};
    endtask

    task automatic idle(int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            in_valid = 1'b0;
        end
    endtask

    task automatic set_gains(int a, int b, int c, int d, int e, int f);
        g[0] = 8'(a); g[1] = 8'(b); g[2] = 8'(c);
        g[3] = 8'(d); g[4] = 8'(e); g[5] = 8'(f);
    endtask

    // monitor: pop and compare each result
    always @(negedge clk) begin
        if (!rst && out_valid) begin
            if (exp_q.size() == 0) begin
                check("R2 unexpected output", 1, 0);
            end else begin
                check(tag_q.pop_front(), longint'(out_data), exp_q.pop_front());
            end
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        check("watchdog", 1, 0);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        longint held;
        int lat;
        set_gains(0, 0, 0, 0, 0, 0);
        m_lfsr = 16'hACE1;
        repeat (3) @(negedge clk);
        check("R1 out_valid in reset", longint'(out_valid), 0);
        check("R1 out_data in reset", longint'(out_data), 0);
        rst = 1'b0;
        @(negedge clk);
        check("R1 out_valid after reset", longint'(out_valid), 0);
        check("R1 out_data after reset", longint'(out_data), 0);

        // R2 latency: present one sample, count edges to out_valid
        send(1234, "R3 dry single");
        lat = 0;
        for (int i = 0; i < 6; i++) begin
            if (i > 0) in_valid = 1'b0;
            @(posedge clk); lat++;
            @(negedge clk);
            in_valid = 1'b0;
            if (out_valid) break;
        end
        check("R2 latency edges", lat, 3);
        idle(4);

        // R3: all gains zero, output equals input, back to back
        send(0, "R3 dry");
        send(32767, "R3 dry");
        send(-32768, "R3 dry");
        send(-5, "R3 dry");
        idle(5);

        // R4 / R9: square only, including -1*-1
        set_gains(64, 0, 0, 0, 0, 0);
        send(-32768, "R4 square -1*-1");
        send(16384, "R4 square");
        send(-12345, "R4 square floor");
        set_gains(64, 0, 0, 0, 0, 0);
        idle(5);
        set_gains(200, 0, 0, 0, 0, 0);
        send(9999, "R4 R9 square gain 200");
        idle(5);

        // R5: upper powers with boost, one at a time
        set_gains(0, 64, 0, 0, 0, 0);
        send(20000, "R5 cube");
        send(-20000, "R5 cube neg");
        idle(5);
        set_gains(0, 0, 64, 0, 0, 0);
        send(-25000, "R5 fourth");
        send(30000, "R5 fourth");
        idle(5);
        set_gains(0, 0, 0, 64, 0, 0);
        send(-30000, "R5 fifth");
        send(28000, "R5 fifth");
        idle(5);

        // R6: clip only
        set_gains(0, 0, 0, 0, 64, 0);
        send(20000, "R6 clip pos");
        send(-20000, "R6 clip neg");
        send(5000, "R6 clip inside");
        send(8192, "R6 clip edge");
        idle(5);

        // R7: fuzz only, with gaps in the stream
        set_gains(0, 0, 0, 0, 0, 128);
        for (int i = 0; i < 20; i++) begin
            send(longint'(i * 3001 - 30000), "R7 fuzz");
            if (i % 3 == 0) idle(2);
        end
        idle(5);

        // R8: saturation at both rails
        set_gains(255, 255, 255, 255, 255, 0);
        send(32767, "R8 saturate high");
        idle(5);
        set_gains(0, 255, 0, 255, 255, 0);
        send(-30000, "R8 saturate low");
        idle(5);

        // full mix
        set_gains(30, 20, 10, 5, 40, 60);
        for (int i = 0; i < 16; i++) send(longint'(i * 4000 - 32000), "R9 full mix");
        idle(5);

        // R10: output holds while out_valid low
        held = longint'(out_data);
        idle(7);
        check("R10 hold", longint'(out_data), held);
        // LFSR did not step across the idle gap: fuzz result still matches model
        set_gains(0, 0, 0, 0, 0, 64);
        send(-17000, "R10 R7 lfsr idle");
        idle(6);
        check("R2 queue drained", exp_q.size(), 0);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule